// File: doc/BRIEF.md
# Supply Power-Up Sequencing Controller

This block brings a set of three supply regulators up in a fixed chain and then watches them. It takes four undervoltage flags that have already been turned into logic levels. Bit 0 reports the main rail. Bit k+1 reports the rail that enable k switches on. From these flags it drives three enable outputs and one power-good output. None of these outputs is allowed to change on a momentary condition. Each step must be backed by a flag, or a pair or set of flags, that has stayed good without a break for a timed window. There are two window lengths. A long window covers the main rail at start-up and the final power-good decision. A short window covers each intermediate enable and every fault.

Once power-good is reached, the block handles faults differently. If the main rail drops, the whole chain collapses and the sequence starts over from the beginning. If one of the three downstream rails drops, only power-good is withdrawn. The enables stay on, and power-good returns after the long window once all rails are good again. The window lengths are parameters written in microseconds at a given clock frequency. Each input goes through a two-flop synchronizer before any logic uses it.

Top module: `supply_sequencer`

## Requirements
- R1: While rst_n is low, en_o is 3'b000 and pgood_o is 0. Reset acts asynchronously.
- R2: From the start state (all outputs low), en_o[0] rises once rail_ok_i[0] has been high for the long window without a break. No other output changes.
- R3: With only en_o[0] on, en_o[1] rises once rail_ok_i[0] and rail_ok_i[1] have both been high for the short window.
- R4: With en_o[1:0] on, en_o[2] rises once rail_ok_i[0] and rail_ok_i[2] have both been high for the short window.
- R5: With all three enables on and pgood_o low, pgood_o rises once all four rail_ok_i bits have been high together for the long window.
- R6: A qualification window restarts from zero whenever its condition breaks, and the condition must then hold for the full window again. The window starts counting no earlier than entry to the current state.
- R7: In any state other than start, rail_ok_i[0] low for the short window clears every enable and pgood_o in the same cycle. The block then returns to start, and the whole sequence runs again from the R2 qualification.
- R8: With pgood_o high, any of rail_ok_i[3:1] low for the short window (while the main rail stays good) clears only pgood_o, and en_o stays 3'b111. pgood_o later returns as in R5.
- R9: A low pulse on rail_ok_i[0] shorter than the short window has no effect on any output.
- R10: The outputs are cumulative: en_o[1] implies en_o[0], en_o[2] implies en_o[1], and pgood_o implies en_o == 3'b111.
- R11: Inputs take two synchronizer cycles to reach the logic. A window of N cycles that begins with an input change applied between clock edges changes the outputs right after the (N+2)-th following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_ok_i | input | 4 | Asynchronous rail-good flags; bit 0 is the main rail, bit k+1 is the rail enabled by en_o[k] |
| en_o | output | 3 | Regulator enables, bit k enables stage k |
| pgood_o | output | 1 | System power-good |

## Verification
The timing assertions assume that each rail flag stays stable long enough to be caught by the synchronizer. They look back exactly three clock samples, covering the two synchronizer stages plus the state register, to find the flag value that caused a transition. The bench therefore changes the flags only at falling clock edges. Each level is held for at least one whole cycle, so every change is seen, and no flag changes between samples in a way that could be missed. The random segments are biased toward good rails so that the chain regularly reaches power-good. They also include main-rail and downstream drops of varied length, some shorter and some longer than the short window.

// File: rtl/supply_sequencer.sv
module supply_sequencer #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned LONG_US  = 190_000,
  parameter int unsigned SHORT_US = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rail_ok_i,
  output logic [2:0] en_o,
  output logic       pgood_o
);

  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned LONG_CYC   = CYC_PER_US * LONG_US;
  localparam int unsigned SHORT_CYC  = CYC_PER_US * SHORT_US;
  localparam int unsigned AW         = $clog2(LONG_CYC + 1);
  localparam int unsigned FW         = $clog2(SHORT_CYC + 1);
  localparam logic [AW-1:0] LONG_LIM_A  = AW'(LONG_CYC - 1);
  localparam logic [AW-1:0] SHORT_LIM_A = AW'(SHORT_CYC - 1);
  localparam logic [FW-1:0] SHORT_LIM_F = FW'(SHORT_CYC - 1);

  typedef enum logic [2:0] {
    S_OFF  = 3'd0,
    S_E1   = 3'd1,
    S_E12  = 3'd2,
    S_E123 = 3'd3,
    S_PG   = 3'd4
  } seq_t;

  seq_t          state, state_nx;
  logic [3:0]    sync_q1, sync_q2;
  logic [AW-1:0] adv_cnt;
  logic [FW-1:0] main_cnt, sec_cnt;
  logic          adv_hold, adv_long, adv_fire;
  logic          main_hold, main_fire;
  logic          sec_hold, sec_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= '0;
      sync_q2 <= '0;
    end else begin
      sync_q1 <= rail_ok_i;
      sync_q2 <= sync_q1;
    end
  end

  always_comb begin
    case (state)
      S_OFF:   adv_hold = sync_q2[0];
      S_E1:    adv_hold = sync_q2[0] & sync_q2[1];
      S_E12:   adv_hold = sync_q2[0] & sync_q2[2];
      S_E123:  adv_hold = &sync_q2;
      default: adv_hold = 1'b0;
    endcase
  end

  assign adv_long  = (state == S_OFF) || (state == S_E123);
  assign adv_fire  = adv_hold && (adv_cnt == (adv_long ? LONG_LIM_A : SHORT_LIM_A));
  assign main_hold = (state != S_OFF) && !sync_q2[0];
  assign main_fire = main_hold && (main_cnt == SHORT_LIM_F);
  assign sec_hold  = (state == S_PG) && !(&sync_q2[3:1]);
  assign sec_fire  = sec_hold && (sec_cnt == SHORT_LIM_F);

  always_comb begin
    state_nx = state;
    if (main_fire)
      state_nx = S_OFF;
    else if (sec_fire)
      state_nx = S_E123;
    else if (adv_fire) begin
      case (state)
        S_OFF:   state_nx = S_E1;
        S_E1:    state_nx = S_E12;
        S_E12:   state_nx = S_E123;
        S_E123:  state_nx = S_PG;
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      adv_cnt  <= '0;
      main_cnt <= '0;
      sec_cnt  <= '0;
    end else begin
      state    <= state_nx;
      adv_cnt  <= (adv_hold  && !adv_fire)  ? adv_cnt + 1'b1  : '0;
      main_cnt <= (main_hold && !main_fire) ? main_cnt + 1'b1 : '0;
      sec_cnt  <= (sec_hold  && !sec_fire)  ? sec_cnt + 1'b1  : '0;
    end
  end

  always_comb begin
    case (state)
      S_E1:    en_o = 3'b001;
      S_E12:   en_o = 3'b011;
      S_E123:  en_o = 3'b111;
      S_PG:    en_o = 3'b111;
      default: en_o = 3'b000;
    endcase
  end

  assign pgood_o = (state == S_PG);

endmodule

// File: rtl/supply_sequencer_props.sv
module supply_sequencer_props (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rail_ok_i,
  input logic [2:0] en_o,
  input logic       pgood_o
);

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> (en_o == 3'b000) && !pgood_o);

  assert_en0_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o[0]) |-> $past(rail_ok_i[0], 3) && (en_o[2:1] == 2'b00) && !pgood_o);

  assert_en1_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o[1]) |-> $past(rail_ok_i[0] & rail_ok_i[1], 3));

  assert_en2_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o[2]) |-> $past(rail_ok_i[0] & rail_ok_i[2], 3));

  assert_pg_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> $past(&rail_ok_i, 3));

  assert_main_collapse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_o[0]) |-> !$past(rail_ok_i[0], 3) && (en_o == 3'b000) && !pgood_o);

  assert_sec_keeps_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pgood_o) && en_o[0]) |-> (en_o == 3'b111) && !$past(&rail_ok_i[3:1], 3));

  assert_cumulative_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o[1] || en_o[0]) && (!en_o[2] || en_o[1]) && (!pgood_o || (en_o == 3'b111)));

endmodule

bind supply_sequencer supply_sequencer_props u_props (.*);

// File: tb/supply_sequencer_bench.sv
`timescale 1ns/1ps
module supply_sequencer_bench;

  localparam int NL = 24;
  localparam int NS = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rails = 4'b0000;
  logic [2:0] en_o;
  logic       pgood_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  supply_sequencer #(.CLK_HZ(1_000_000), .LONG_US(NL), .SHORT_US(NS)) u_supply_sequencer (
    .clk(clk), .rst_n(rst_n), .rail_ok_i(rails), .en_o(en_o), .pgood_o(pgood_o)
  );

  // reference: state plus run lengths of held conditions
  int m_state = 0, m_dwell = 0, m_mrun = 0, m_srun = 0;
  int m_len [4] = '{0, 0, 0, 0};
  logic [3:0] m_sa = '0, m_sb = '0;

  function automatic logic [2:0] exp_en(int s);
    return {s >= 3, s >= 2, s >= 1};
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_dwell = 0; m_mrun = 0; m_srun = 0;
      for (int i = 0; i < 4; i++) m_len[i] = 0;
      m_sa = '0; m_sb = '0;
    end else begin
      int held, nxt;
      for (int i = 0; i < 4; i++) m_len[i] = m_sb[i] ? m_len[i] + 1 : 0;
      m_dwell = m_dwell + 1;
      m_mrun = (m_state != 0 && !m_sb[0]) ? m_mrun + 1 : 0;
      m_srun = (m_state == 4 && !(&m_sb[3:1])) ? m_srun + 1 : 0;
      nxt = m_state;
      case (m_state)
        0: held = m_len[0];
        1: held = min2(m_len[0], m_len[1]);
        2: held = min2(m_len[0], m_len[2]);
        3: held = min2(min2(m_len[0], m_len[1]), min2(m_len[2], m_len[3]));
        default: held = 0;
      endcase
      held = min2(held, m_dwell);
      if (m_mrun >= NS) nxt = 0;
      else if (m_srun >= NS) nxt = 3;
      else if (m_state < 4 && held >= ((m_state == 0 || m_state == 3) ? NL : NS)) nxt = m_state + 1;
      if (nxt != m_state) m_dwell = 0;
      m_state = nxt;
      m_sb = m_sa;
      m_sa = rails;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  // cycle-by-cycle scoreboard
  always @(negedge clk) begin
    if (!done) begin
      string req;
      case (m_state)
        0: req = "R2"; 1: req = "R3"; 2: req = "R4"; 3: req = "R8"; default: req = "R5";
      endcase
      check(en_o == exp_en(m_state), req, "en_o", en_o, exp_en(m_state));
      check(pgood_o == (m_state == 4), req, "pgood_o", pgood_o, m_state == 4);
    end
  end

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(logic [2:0] e, logic p, string req);
    check(en_o == e, req, "directed en_o", en_o, e);
    check(pgood_o == p, req, "directed pgood_o", pgood_o, p);
  endtask

  initial begin
    #(4 * 190_000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    edges(3);
    expect_out(3'b000, 1'b0, "R1");
    rst_n = 1'b1;

    // R6: interrupted qualification restarts
    edges(1); rails = 4'b0001;
    edges(NL - 3); rails = 4'b0000;
    edges(1); rails = 4'b0001;
    edges(NL + 1); expect_out(3'b000, 1'b0, "R6");
    // R11 / R2: exact latency
    edges(1); expect_out(3'b001, 1'b0, "R11");

    // R3, R4, R5 chain
    rails = 4'b0011;
    edges(NS + 1); expect_out(3'b001, 1'b0, "R3");
    edges(1);      expect_out(3'b011, 1'b0, "R3");
    rails = 4'b0111;
    edges(NS + 1); expect_out(3'b011, 1'b0, "R4");
    edges(1);      expect_out(3'b111, 1'b0, "R4");
    rails = 4'b1111;
    edges(NL + 1); expect_out(3'b111, 1'b0, "R5");
    edges(1);      expect_out(3'b111, 1'b1, "R5");

    // R9: short main-rail dip ignored
    rails = 4'b1110;
    edges(NS - 1); rails = 4'b1111;
    edges(NS + 6); expect_out(3'b111, 1'b1, "R9");

    // R8: downstream drop keeps enables
    rails = 4'b1011;
    edges(NS + 1); expect_out(3'b111, 1'b1, "R8");
    edges(1);      expect_out(3'b111, 1'b0, "R8");
    rails = 4'b1111;
    edges(NL + 1); expect_out(3'b111, 1'b0, "R8");
    edges(1);      expect_out(3'b111, 1'b1, "R8");

    // R7: main-rail fault collapses and restarts
    rails = 4'b1110;
    edges(NS + 1); expect_out(3'b111, 1'b1, "R7");
    edges(1);      expect_out(3'b000, 1'b0, "R7");
    rails = 4'b1111;
    edges(NL + 1);  expect_out(3'b000, 1'b0, "R7");
    edges(1);       expect_out(3'b001, 1'b0, "R7");
    edges(NS);      expect_out(3'b011, 1'b0, "R7");
    edges(NS);      expect_out(3'b111, 1'b0, "R7");
    edges(NL);      expect_out(3'b111, 1'b1, "R7");

    // R1: asynchronous reset from power-good
    rst_n = 1'b0;
    #1 expect_out(3'b000, 1'b0, "R1");
    edges(2); rst_n = 1'b1;

    // constrained random
    for (int seg = 0; seg < 2500; seg++) begin
      logic [3:0] r;
      int hold;
      r[0] = ($urandom % 14) != 0;
      for (int b = 1; b < 4; b++) r[b] = ($urandom % 9) != 0;
      hold = 1 + ($urandom % ((seg % 3 == 0) ? 8 : 40));
      rails = r;
      edges(hold);
      check(!pgood_o || en_o == 3'b111, "R10", "cumulative", {pgood_o, en_o}, 4'b1111);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule